// File: doc/BRIEF.md
# Integer Arithmetic Logic Unit

This block is the purely combinational arithmetic and logic stage of a small RISC integer datapath. Two operand words and a three-bit operation code enter. A result word leaves, together with three flags: zero, signed overflow and carry-out. There is no clock and no state, so the outputs follow the inputs within one propagation delay.

One adder serves addition, subtraction and the signed comparison. The top bit of the operation code tells that adder to take the complement of the second operand and to force its carry-in high. A signed less-than test reuses the difference. The sign bit of the difference is corrected by the overflow flag and the outcome is placed in bit 0 of an otherwise cleared result. Opcodes that carry no operation give a quiet, all-zero answer.

Top module: `int_alu_top`

## Requirements
- R1: Opcode 000 returns the bitwise AND of opA and opB.
- R2: Opcode 001 returns the bitwise OR of opA and opB.
- R3: Opcode 010 returns opA + opB modulo 2^32.
- R4: Opcode 110 returns opA - opB modulo 2^32. It is computed as opA + ~opB + 1.
- R5: Opcode 111 returns 1 in bit 0 when opA is less than opB as two's-complement numbers, and 0 otherwise. Bits 31..1 are 0. The answer is correct even when opA - opB overflows.
- R6: zero is 1 exactly when all result bits are 0, for every opcode.
- R7: overflow is 1 in two cases only. For opcode 010, both operands have the same sign and the sum has the other sign. For opcodes 110 and 111, the operands differ in sign and the difference's sign differs from opA. For every other opcode, overflow is 0.
- R8: carryOut is the carry out of bit 31 of the adder for opcodes 010, 110 and 111. For subtraction this equals opA >= opB unsigned. For all other opcodes carryOut is 0.
- R9: Opcodes 011, 100 and 101 give a result of all zeros with overflow 0 and carryOut 0, and therefore zero = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| opCode | input | 3 | Operation select |
| result | output | 32 | Operation result |
| zero | output | 1 | All result bits clear |
| overflow | output | 1 | Signed overflow of the arithmetic path |
| carryOut | output | 1 | Carry out of the most significant adder bit |

## Verification
The bench drives operand pairs that sit at the signed and unsigned extremes: 0, 1, all ones, 0x7FFFFFFF and 0x80000000.

- A design that took raw sign instead of sign XOR overflow would get the comparison of 0x80000000 against 1 backwards.
- A subtractor missing its forced carry-in would be off by one on every difference, for example 5 - 5 would not set zero.
- Flags leaking from the adder into the logical or unused opcodes would show up as stray overflow or carry values.
- An overflow rule written for addition only would miss the opposite-sign cases of subtraction.

Random operands on every opcode then cover the ordinary cases.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  typedef enum logic [2:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } aluOp_e;

  typedef enum logic [2:0] {
    RES_AND,
    RES_OR,
    RES_SUM,
    RES_LESS,
    RES_NONE
  } resSel_e;

  typedef struct packed {
    logic    invertB;
    logic    carryIn;
    logic    arith;
    resSel_e resSel;
  } aluCtrl_t;

endpackage

// File: rtl/int_alu_ctrl.sv
module int_alu_ctrl
  import int_alu_pkg::*;
(
  input  logic [2:0] opCode,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl.invertB = opCode[2];
    ctrl.carryIn = opCode[2];
    ctrl.arith   = 1'b0;
    ctrl.resSel  = RES_NONE;
    unique case (opCode)
      OP_AND: ctrl.resSel = RES_AND;
      OP_OR:  ctrl.resSel = RES_OR;
      OP_ADD: begin ctrl.resSel = RES_SUM;  ctrl.arith = 1'b1; end
      OP_SUB: begin ctrl.resSel = RES_SUM;  ctrl.arith = 1'b1; end
      OP_SLT: begin ctrl.resSel = RES_LESS; ctrl.arith = 1'b1; end
      default: begin
        ctrl.resSel  = RES_NONE;
        ctrl.invertB = 1'b0;
        ctrl.carryIn = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/int_alu_adder.sv
module int_alu_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] addA,
  input  logic [WIDTH-1:0] addB,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);

  logic [WIDTH:0] carryChain;

  assign carryChain[0] = cin;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      assign sum[i]          = addA[i] ^ addB[i] ^ carryChain[i];
      assign carryChain[i+1] = (addA[i] & addB[i]) | (carryChain[i] & (addA[i] ^ addB[i]));
    end
  endgenerate

  assign cout = carryChain[WIDTH];
  assign ovf  = carryChain[WIDTH] ^ carryChain[WIDTH-1];

endmodule

// File: rtl/int_alu_datapath.sv
module int_alu_datapath
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluCtrl_t         ctrl,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow,
  output logic             carryOut
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bOperand;
  logic [WIDTH-1:0] sumWord;
  logic             addCarry;
  logic             addOvf;
  logic             lessBit;

  assign bOperand = ctrl.invertB ? ~opB : opB;

  int_alu_adder #(.WIDTH(WIDTH)) adder_i (
    .addA (opA),
    .addB (bOperand),
    .cin  (ctrl.carryIn),
    .sum  (sumWord),
    .cout (addCarry),
    .ovf  (addOvf)
  );

  assign lessBit = sumWord[MSB] ^ addOvf;

  always_comb begin
    result = '0;
    unique case (ctrl.resSel)
      RES_AND:  result = opA & opB;
      RES_OR:   result = opA | opB;
      RES_SUM:  result = sumWord;
      RES_LESS: result = {{(WIDTH-1){1'b0}}, lessBit};
      default:  result = '0;
    endcase
  end

  assign zero     = ~|result;
  assign overflow = ctrl.arith & addOvf;
  assign carryOut = ctrl.arith & addCarry;

endmodule

// File: rtl/int_alu_top.sv
module int_alu_top
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       opCode,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow,
  output logic             carryOut
);

  aluCtrl_t ctrl;

  int_alu_ctrl ctrl_i (
    .opCode (opCode),
    .ctrl   (ctrl)
  );

  int_alu_datapath #(.WIDTH(WIDTH)) dp_i (
    .opA      (opA),
    .opB      (opB),
    .ctrl     (ctrl),
    .result   (result),
    .zero     (zero),
    .overflow (overflow),
    .carryOut (carryOut)
  );

endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [2:0]       opCode,
  input logic [WIDTH-1:0] result,
  input logic             zero,
  input logic             overflow,
  input logic             carryOut
);

  localparam int MSB = WIDTH - 1;

  always_comb begin
    if (!$isunknown({opA, opB, opCode})) begin
      assert_zero_flag_R6: assert (zero == (result == '0));
      if (opCode == 3'b000 || opCode == 3'b001) begin
        assert_no_overflow_R7: assert (overflow == 1'b0);
        assert_no_carry_R8: assert (carryOut == 1'b0);
      end
      if (opCode == 3'b111)
        assert_less_upper_clear_R5: assert (result[WIDTH-1:1] == '0);
      if (opCode == 3'b011 || opCode == 3'b100 || opCode == 3'b101)
        assert_unused_quiet_R9: assert (result == '0 && !overflow && !carryOut);
      if (opCode == 3'b010 && opA[MSB] == opB[MSB] && result[MSB] != opA[MSB])
        assert_add_overflow_R7: assert (overflow);
      if (opCode == 3'b010 && opA[MSB] != opB[MSB])
        assert_add_mixed_sign_R3: assert (!overflow);
    end
  end

endmodule

bind int_alu_top int_alu_chk #(.WIDTH(WIDTH)) chk_i (
  .opA      (opA),
  .opB      (opB),
  .opCode   (opCode),
  .result   (result),
  .zero     (zero),
  .overflow (overflow),
  .carryOut (carryOut)
);

// File: tb/int_alu_top_tb_top.sv
module int_alu_top_tb_top;

  logic        clk = 1'b0;
  logic [31:0] opA;
  logic [31:0] opB;
  logic [2:0]  opCode;
  logic [31:0] result;
  logic        zero;
  logic        overflow;
  logic        carryOut;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  int_alu_top dut_i (
    .opA      (opA),
    .opB      (opB),
    .opCode   (opCode),
    .result   (result),
    .zero     (zero),
    .overflow (overflow),
    .carryOut (carryOut)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s op=%b a=%h b=%h actual=%h expected=%h", tag, what, opCode, opA, opB, act, exp);
    end
  endtask

  task automatic runOne(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [32:0] wide;
    logic [31:0] expRes;
    logic        expOvf;
    logic        expCarry;
    string       tag;
    @(negedge clk);
    opCode = op; opA = a; opB = b;
    expRes = '0; expOvf = 1'b0; expCarry = 1'b0; tag = "R9";
    case (op)
      3'b000: begin tag = "R1"; expRes = a & b; end
      3'b001: begin tag = "R2"; expRes = a | b; end
      3'b010: begin
        tag = "R3";
        wide = {1'b0, a} + {1'b0, b};
        expRes = wide[31:0]; expCarry = wide[32];
        expOvf = ($signed(a) + $signed(b)) != longint'($signed(expRes));
      end
      3'b110: begin
        tag = "R4";
        expRes = a - b; expCarry = (a >= b);
        expOvf = (longint'($signed(a)) - longint'($signed(b))) != longint'($signed(expRes));
      end
      3'b111: begin
        tag = "R5";
        expRes = {31'b0, ($signed(a) < $signed(b))}; expCarry = (a >= b);
        expOvf = (longint'($signed(a)) - longint'($signed(b))) != longint'($signed(a - b));
      end
      default: tag = "R9";
    endcase
    @(posedge clk); #1;
    check(tag, "result", result, expRes);
    check("R6", "zero", {31'b0, zero}, {31'b0, (expRes == 0)});
    check("R7", "overflow", {31'b0, overflow}, {31'b0, expOvf});
    check("R8", "carryOut", {31'b0, carryOut}, {31'b0, expCarry});
  endtask

  initial begin
    logic [31:0] corners [8];
    corners[0] = 32'h0000_0000; corners[1] = 32'h0000_0001;
    corners[2] = 32'hFFFF_FFFF; corners[3] = 32'h7FFF_FFFF;
    corners[4] = 32'h8000_0000; corners[5] = 32'h8000_0001;
    corners[6] = 32'hFFFF_FFFE; corners[7] = 32'h5555_AAAA;
    opA = '0; opB = '0; opCode = 3'b000;
    // reset-like start: all-zero inputs on AND give zero result, R1 and R6
    @(posedge clk); #1;
    check("R1", "idle result", result, 32'h0);
    check("R6", "idle zero", {31'b0, zero}, 32'h1);
    // R5 overflow-corrected compare: most negative vs 1
    runOne(3'b111, 32'h8000_0000, 32'h0000_0001);
    runOne(3'b111, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    // R4 equal operands give zero
    runOne(3'b110, 32'h0000_0005, 32'h0000_0005);
    // R7 add overflow both directions
    runOne(3'b010, 32'h7FFF_FFFF, 32'h0000_0001);
    runOne(3'b010, 32'h8000_0000, 32'h8000_0000);
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          runOne(op[2:0], corners[i], corners[j]);
    for (int n = 0; n < 3000; n++)
      runOne(3'($urandom_range(0, 7)), $urandom, $urandom);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule